// File: doc/BRIEF.md
# Multi-Channel DAC SPI Command Engine

This block turns short command requests into 24-bit frames for a multi-channel DAC on an SPI link that idles SCLK low and samples on the falling edge (clock phase 1). Each request carries a kind, a channel number and a 16-bit value. The engine builds the frame, divides the system clock down to SCLK and shifts the frame out MSB first, with an active-low chip select held for the whole frame.

Channel data, offset and gain writes take one frame each, and so do special-function writes. Two kinds of request take two frames. An offset-DAC update sends the same 14-bit value to both offset-DAC registers, one frame after the other. A register readback sends a read-select frame, keeps chip select high for a minimum gap, and then sends a NOP frame at a slower SCLK while it shifts in MISO. The low 16 bits that come back appear on a read-data output with a one-cycle valid strobe.

The command port is valid/ready. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` then stays low until the last frame of that request has ended, and a request offered while it is low is not taken. The read-data output has no back-pressure: `rd_valid` is a single-cycle pulse that the consumer must capture.

Top module: `dacspi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, `req_ready` is high and `rd_valid` is low.
- R2: Every frame is 24 SCLK pulses inside one chip-select-low window, MSB first. SCLK is low whenever chip select is high, MOSI changes only on rising SCLK edges, and chip select returns high after each frame.
- R3: `req_kind` 0, 1 and 2 write the channel data, offset and gain registers. Bits [23:22] are 3, 2 and 1 respectively, bits [21:16] are `req_chan`+8, and bits [15:0] are `req_value`.
- R4: `req_kind` 3 (and the unused codes 6 and 7) sends a special-function frame. Bits [23:22] are 0, bits [21:16] are the low six bits of `req_chan` used as the function code, and bits [15:0] are `req_value`.
- R5: `req_kind` 5 sends two frames. The first has function code 2 and the second has function code 3. Both have mode 0 and carry `req_value` masked to 14 bits, with bits [15:14] zero.
- R6: `req_kind` 4 (readback) first sends a frame with mode 0, function code 5 and bits [15:0] = `req_value` + (`req_chan` << 7), modulo 2^16.
- R7: Between the two frames of a readback, chip select stays high for at least `GAP_CYC` system-clock cycles (270 ns at the defaults).
- R8: The second readback frame is a NOP (all 24 bits zero). MISO is sampled on each falling SCLK edge of that frame, and the last 16 bits sampled appear on `rd_data` with exactly one cycle of `rd_valid`.
- R9: `req_ready` goes low in the cycle after a request is accepted and stays low until the last frame has ended. A request offered while `req_ready` is low sends no frame.
- R10: The SCLK period is `WR_DIV` system-clock cycles for every write frame and for the readback select frame, and `RD_DIV` cycles for the readback NOP frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_kind | input | 3 | 0 data, 1 offset, 2 gain, 3 special, 4 readback, 5 offset-DAC pair |
| req_chan | input | CH_W | Channel number, or function code for kind 3 |
| req_value | input | 16 | Register value, or register select for a readback |
| rd_valid | output | 1 | One-cycle strobe for readback data |
| rd_data | output | 16 | Readback result |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_miso | input | 1 | Serial data from the DAC |

## Verification
The hardest case to reach is the readback. The engine must leave chip select high for the enforced gap, then switch to the slow divider for the NOP frame, while the DAC drives MISO in step with the engine's own SCLK. The bench includes a small DAC-side model. It launches a chosen 24-bit reply on each rising SCLK edge, and it timestamps the chip-select edges and the SCLK rising edges. This lets one readback request check the select frame, the gap length, both SCLK periods and the returned word. A separate scenario holds `req_valid` high during a frame to show that a request offered while the engine is busy is not taken.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;
  localparam int FRAME_W = 24;
  localparam int VAL_W   = 16;
  localparam int ADDR_W  = 6;
  localparam int CH_BASE = 8;

  typedef enum logic [2:0] {
    K_DATA    = 3'd0,
    K_OFFSET  = 3'd1,
    K_GAIN    = 3'd2,
    K_SPECIAL = 3'd3,
    K_READ    = 3'd4,
    K_OFSDAC  = 3'd5,
    K_RSV6    = 3'd6,
    K_RSV7    = 3'd7
  } req_kind_e;

  localparam logic [1:0] MODE_DATA    = 2'd3;
  localparam logic [1:0] MODE_OFFSET  = 2'd2;
  localparam logic [1:0] MODE_GAIN    = 2'd1;
  localparam logic [1:0] MODE_SPECIAL = 2'd0;

  localparam logic [ADDR_W-1:0] FN_NOP  = 6'd0;
  localparam logic [ADDR_W-1:0] FN_OFS0 = 6'd2;
  localparam logic [ADDR_W-1:0] FN_OFS1 = 6'd3;
  localparam logic [ADDR_W-1:0] FN_READ = 6'd5;
endpackage

// File: rtl/dacspi_frame_build.sv
module dacspi_frame_build
  import dacspi_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic [2:0]         kind,
  input  logic [CH_W-1:0]    chan,
  input  logic [VAL_W-1:0]   value,
  input  logic               second,
  output logic [FRAME_W-1:0] frame,
  output logic               two_frame,
  output logic               is_read
);
  logic [ADDR_W-1:0] chan_ext;
  logic [ADDR_W-1:0] chan_addr;
  logic [VAL_W-1:0]  rd_sel;

  assign chan_ext  = ADDR_W'(chan);
  assign chan_addr = chan_ext + ADDR_W'(CH_BASE);
  assign rd_sel    = value + (VAL_W'(chan) << 7);

  always_comb begin
    two_frame = 1'b0;
    is_read   = 1'b0;
    case (kind)
      K_DATA:   frame = {MODE_DATA, chan_addr, value};
      K_OFFSET: frame = {MODE_OFFSET, chan_addr, value};
      K_GAIN:   frame = {MODE_GAIN, chan_addr, value};
      K_READ: begin
        two_frame = 1'b1;
        is_read   = 1'b1;
        frame = second ? {MODE_SPECIAL, FN_NOP, {VAL_W{1'b0}}}
                       : {MODE_SPECIAL, FN_READ, rd_sel};
      end
      K_OFSDAC: begin
        two_frame = 1'b1;
        frame = {MODE_SPECIAL, (second ? FN_OFS1 : FN_OFS0), 2'b00, value[13:0]};
      end
      default:  frame = {MODE_SPECIAL, chan_ext, value};
    endcase
  end
endmodule

// File: rtl/dacspi_shifter.sv
module dacspi_shifter
  import dacspi_pkg::*;
#(
  parameter int HALF_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [HALF_W-1:0]  half_cyc,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  output logic [VAL_W-1:0]   rx,
  output logic               done
);
  localparam int BC_W = $clog2(FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} sh_st_e;
  sh_st_e              st;
  logic [HALF_W-1:0]   hc;
  logic [HALF_W-1:0]   hlim;
  logic [BC_W-1:0]     bitcnt;
  logic [FRAME_W-1:0]  tx;

  assign hlim = half_cyc - HALF_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      hc <= '0; bitcnt <= '0; tx <= '0; rx <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; cs_n <= 1'b0; tx <= frame;
          hc <= '0; bitcnt <= '0; rx <= '0;
        end
        S_RUN: begin
          if (hc == hlim) begin
            hc   <= '0;
            sclk <= ~sclk;
            if (!sclk) begin
              mosi <= tx[FRAME_W-1];
              tx   <= {tx[FRAME_W-2:0], 1'b0};
            end else begin
              rx <= {rx[VAL_W-2:0], miso};
              if (bitcnt == BC_W'(FRAME_W-1)) st <= S_TAIL;
              else bitcnt <= bitcnt + BC_W'(1);
            end
          end else begin
            hc <= hc + HALF_W'(1);
          end
        end
        default: begin
          if (hc == hlim) begin
            hc <= '0; cs_n <= 1'b1; done <= 1'b1; mosi <= 1'b0; st <= S_IDLE;
          end else begin
            hc <= hc + HALF_W'(1);
          end
        end
      endcase
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_mosi_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $fell(sclk)) |-> $stable(mosi));
  assert_done_release_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !$past(cs_n)));
endmodule

// File: rtl/dacspi_seq.sv
module dacspi_seq
  import dacspi_pkg::*;
#(
  parameter int CH_W    = 5,
  parameter int GAP_CYC = 54
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [VAL_W-1:0] req_value,
  output logic [2:0]       lat_kind,
  output logic [CH_W-1:0]  lat_chan,
  output logic [VAL_W-1:0] lat_value,
  input  logic             two_frame,
  input  logic             is_read,
  output logic             second,
  output logic             start,
  output logic             slow,
  output logic             rd_phase,
  input  logic             done,
  input  logic [VAL_W-1:0] rx,
  output logic             rd_valid,
  output logic [VAL_W-1:0] rd_data
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {Q_IDLE, Q_L0, Q_W0, Q_GAP, Q_L1, Q_W1} q_st_e;
  q_st_e            st;
  logic [GAP_W-1:0] gcnt;

  assign req_ready = (st == Q_IDLE);
  assign start     = (st == Q_L0) || (st == Q_L1);
  assign second    = (st == Q_L1) || (st == Q_W1);
  assign slow      = second && is_read;
  assign rd_phase  = slow;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= Q_IDLE; gcnt <= '0; rd_valid <= 1'b0; rd_data <= '0;
      lat_kind <= '0; lat_chan <= '0; lat_value <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        Q_IDLE: if (req_valid) begin
          lat_kind <= req_kind; lat_chan <= req_chan; lat_value <= req_value;
          st <= Q_L0;
        end
        Q_L0: st <= Q_W0;
        Q_W0: if (done) begin
          if (!two_frame) st <= Q_IDLE;
          else if (is_read) begin st <= Q_GAP; gcnt <= '0; end
          else st <= Q_L1;
        end
        Q_GAP: begin
          if (gcnt == GAP_W'(GAP_CYC - 1)) st <= Q_L1;
          else gcnt <= gcnt + GAP_W'(1);
        end
        Q_L1: st <= Q_W1;
        default: if (done) begin
          st <= Q_IDLE;
          if (is_read) begin rd_valid <= 1'b1; rd_data <= rx; end
        end
      endcase
    end
  end

  assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  assert_rd_idle_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> req_ready);
endmodule

// File: rtl/dacspi_cmd_engine.sv
module dacspi_cmd_engine
  import dacspi_pkg::*;
#(
  parameter int CH_W    = 5,
  parameter int WR_DIV  = 4,
  parameter int RD_DIV  = 16,
  parameter int GAP_CYC = 54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [15:0]       req_value,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int WR_HALF = WR_DIV / 2;
  localparam int RD_HALF = RD_DIV / 2;
  localparam int MAX_HALF = (WR_HALF > RD_HALF) ? WR_HALF : RD_HALF;
  localparam int HALF_W  = $clog2(MAX_HALF + 1);

  logic [2:0]         lat_kind;
  logic [CH_W-1:0]    lat_chan;
  logic [VAL_W-1:0]   lat_value;
  logic               two_frame, is_read, second, start, slow, rd_phase, done;
  logic [FRAME_W-1:0] frame;
  logic [VAL_W-1:0]   rx;
  logic [HALF_W-1:0]  half_cyc;

  assign half_cyc = slow ? HALF_W'(RD_HALF) : HALF_W'(WR_HALF);

  dacspi_seq #(.CH_W(CH_W), .GAP_CYC(GAP_CYC)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_chan(req_chan), .req_value(req_value),
    .lat_kind(lat_kind), .lat_chan(lat_chan), .lat_value(lat_value),
    .two_frame(two_frame), .is_read(is_read), .second(second),
    .start(start), .slow(slow), .rd_phase(rd_phase), .done(done), .rx(rx),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  dacspi_frame_build #(.CH_W(CH_W)) u_build (
    .kind(lat_kind), .chan(lat_chan), .value(lat_value), .second(second),
    .frame(frame), .two_frame(two_frame), .is_read(is_read)
  );

  dacspi_shifter #(.HALF_W(HALF_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .frame(frame), .half_cyc(half_cyc),
    .miso(spi_miso), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .rx(rx), .done(done)
  );

  logic [15:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
  end

  assert_read_gap_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(spi_cs_n) && rd_phase) |-> (32'(hi_cnt) >= GAP_CYC));
  assert_busy_frame_R9: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !req_ready);
endmodule

// File: tb/dacspi_cmd_engine_tb.sv
`timescale 1ns/1ps
module dacspi_cmd_engine_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [4:0] req_chan = '0;
  logic [15:0] req_value = '0;
  logic rd_valid;
  logic [15:0] rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  dacspi_cmd_engine u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_chan(req_chan), .req_value(req_value),
    .rd_valid(rd_valid), .rd_data(rd_data), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_tests = 0;
  int n_fail = 0;

  // DAC-side model
  logic [23:0] frames [64];
  int          nbits  [64];
  real         period [64];
  real         gap_before [64];
  int          nfr = 0;
  logic [23:0] sh;
  int          nb = 0;
  real         t_high = 0.0, t_rise = -1.0, last_per = 0.0;
  logic [23:0] reply = '0;
  logic [23:0] mw;
  int          rdv_cnt = 0;
  logic [15:0] rd_last = '0;

  always @(negedge spi_cs_n) begin
    sh = '0; nb = 0; t_rise = -1.0; mw = reply;
    if (nfr < 64) gap_before[nfr] = $realtime - t_high;
  end
  always @(posedge spi_cs_n) begin
    if (nb > 0 && nfr < 64) begin
      frames[nfr] = sh; nbits[nfr] = nb; period[nfr] = last_per; nfr++;
    end
    t_high = $realtime;
  end
  always @(posedge spi_sclk) begin
    if (t_rise >= 0.0) last_per = $realtime - t_rise;
    t_rise = $realtime;
    spi_miso = mw[23]; mw = {mw[22:0], 1'b0};
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin sh = {sh[22:0], spi_mosi}; nb++; end
  always @(negedge clk) if (rd_valid) begin rdv_cnt++; rd_last = rd_data; end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] k, input logic [4:0] ch, input logic [15:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_kind = k; req_chan = ch; req_value = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    check(spi_sclk === 1'b0, "R1 sclk", spi_sclk, 0);
    check(req_ready === 1'b1, "R1 ready", req_ready, 1);
    check(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_single(input logic [2:0] k, input logic [4:0] ch, input logic [15:0] v,
                          input logic [23:0] exp, input string tag);
    int b = nfr;
    do_req(k, ch, v);
    check(nfr == b + 1, {tag, " frame count"}, nfr - b, 1);
    check(frames[b] == exp, {tag, " frame"}, frames[b], exp);
    check(nbits[b] == 24, "R2 bit count", nbits[b], 24);
    check(period[b] == 20.0, "R10 write sclk period ns", longint'(period[b]), 20);
  endtask

  task automatic t_ofsdac();
    int b = nfr;
    do_req(3'd5, 5'd0, 16'hFFFF);
    check(nfr == b + 2, "R5 frame count", nfr - b, 2);
    check(frames[b] == 24'h023FFF, "R5 first frame", frames[b], 24'h023FFF);
    check(frames[b+1] == 24'h033FFF, "R5 second frame", frames[b+1], 24'h033FFF);
  endtask

  task automatic t_read(input logic [4:0] ch, input logic [15:0] sel, input logic [23:0] rep);
    int b = nfr;
    int c = rdv_cnt;
    logic [15:0] lo = sel + (16'(ch) << 7);
    reply = rep;
    do_req(3'd4, ch, sel);
    check(nfr == b + 2, "R6 frame count", nfr - b, 2);
    check(frames[b] == {8'h05, lo}, "R6 select frame", frames[b], {8'h05, lo});
    check(period[b] == 20.0, "R10 select sclk period ns", longint'(period[b]), 20);
    check(gap_before[b+1] >= 270.0, "R7 cs high gap ns", longint'(gap_before[b+1]), 270);
    check(frames[b+1] == 24'h0, "R8 nop frame", frames[b+1], 0);
    check(nbits[b+1] == 24, "R2 nop bit count", nbits[b+1], 24);
    check(period[b+1] == 80.0, "R10 read sclk period ns", longint'(period[b+1]), 80);
    check(rdv_cnt == c + 1, "R8 rd_valid pulses", rdv_cnt - c, 1);
    check(rd_last == rep[15:0], "R8 rd_data", rd_last, rep[15:0]);
  endtask

  task automatic t_busy();
    int b = nfr;
    int seen_ready = 0;
    @(negedge clk);
    req_kind = 3'd0; req_chan = 5'd1; req_value = 16'h1234; req_valid = 1'b1;
    @(negedge clk);
    req_kind = 3'd2; req_chan = 5'd7; req_value = 16'h5555;
    for (int i = 0; i < 30; i++) begin
      if (req_ready) seen_ready++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(seen_ready == 0, "R9 ready low while busy", seen_ready, 0);
    while (!req_ready) @(negedge clk);
    repeat (10) @(negedge clk);
    check(nfr == b + 1, "R9 busy request ignored", nfr - b, 1);
    check(frames[b] == 24'hC91234, "R9 accepted frame", frames[b], 24'hC91234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single(3'd0, 5'd3,  16'hBEEF, 24'hCBBEEF, "R3 data");
    t_single(3'd1, 5'd0,  16'h8000, 24'h888000, "R3 offset");
    t_single(3'd2, 5'd31, 16'hFFFF, 24'h67FFFF, "R3 gain");
    t_single(3'd3, 5'd1,  16'h0002, 24'h010002, "R4 special");
    t_single(3'd7, 5'd11, 16'h00F0, 24'h0B00F0, "R4 reserved kind");
    t_ofsdac();
    t_read(5'd2, 16'h6400, 24'hA51234);
    t_read(5'd0, 16'h8080, 24'h00FFFF);
    t_busy();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule